// File: doc/BRIEF.md
# Multi-Queue DMA Register File

This block is the software-visible register window of a multi-queue packet DMA engine. It decodes a 4 KiB window of 32-bit words, where the word index is the byte address shifted right by two. It accepts only aligned full-word accesses. Each mapped word behaves according to its access class:

- read-write: stores what is written and returns it.
- write-only: stores what is written, but reads return zero.
- write-one-to-clear: bits written as 1 are cleared.
- read-only: writes are ignored.
- unmapped: reads return zero and writes are ignored.

A few words have side effects beyond storage:

- **Transmit halt register.** A write restarts the transmit queues whose bits are set.
- **Receive halt register.** A write restarts only those receive queues whose bit is set in the data and is currently clear.
- **Ring base registers.** Each queue has one per direction. A write stores an 8-byte-aligned value and loads the same value into that queue's ring pointer.
- **Event register.** It is write-one-to-clear. Engine-side set pulses fill it, and it drives three interrupt lines, one per event group.

The engine side of the block sees the following:

- one-cycle restart pulses, one per queue;
- halt-set and event-set strobes;
- the stored command word.

Top module: `dma_regfile`

## Requirements
- R1: Every read request returns `rvalid` high one cycle later. Only accesses with `be` = 4'hF and `addr[1:0]` = 0 take effect: other writes change nothing, and other reads return 0.
- R2: The command word at byte 0x00C is write-only. A write stores the value and drives it on `cmd_word`, and a read of 0x00C returns 0.
- R3: The control word at 0x000 is read-write and resets to 0x0000_0040. The identity word at 0x008 is read-only, returns `ID_VALUE`, and ignores writes. Every unmapped address reads 0 and ignores writes.
- R4: In the transmit halt word at 0x010, queue i owns bit 31-i, which `tx_halt_set[i]` sets. A full write pulses `tx_restart[i]` for one cycle, in the cycle after the write, for every i whose bit is 1 in the data. All such queues pulse together, and each written 1 clears its halt bit.
- R5: In the receive halt word at 0x014, queue i owns bit 23-i, which `rx_halt_set[i]` sets. A write pulses `rx_restart[i]` only where the data bit is 1 and the halt bit is currently 0. Each written 1 then clears its halt bit.
- R6: The per-queue ring registers sit at these byte addresses: transmit base 0x080+4n, transmit pointer 0x0A0+4n, receive base 0x100+4n, receive pointer 0x120+4n. A base write stores the data with bits [2:0] forced to 0 and copies that value into pointer n. A pointer write stores its data unchanged.
- R7: The event word at 0x004 is write-one-to-clear, and `event_set` bits set it. When a set and a clear land on the same bit in the same cycle, the set wins. Bit 0 is the transmit-frame event, bit 1 is the receive-frame event, and bits [15:8] form the error group.
- R8: The interrupt outputs are registered and follow their event groups: `tx_irq` follows bit 0, `rx_irq` follows bit 1, and `err_irq` follows bits [15:8]. Each line goes high the cycle after a bit of its group is set. It drops only after a clear that leaves its own group all zero. Bits outside the three groups raise no line.
- R9: After reset, all halt bits, events, ring registers, pulses and interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| be | input | 4 | Byte enables; only 4'hF accepted |
| wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid |
| rdata | output | 32 | Read data |
| event_set | input | 32 | Event set strobes from the engine |
| tx_halt_set | input | NQ | Transmit halt set per queue |
| rx_halt_set | input | NQ | Receive halt set per queue |
| tx_restart | output | NQ | Transmit ring restart pulses |
| rx_restart | output | NQ | Receive ring restart pulses |
| tx_irq | output | 1 | Transmit-frame interrupt |
| rx_irq | output | 1 | Receive-frame interrupt |
| err_irq | output | 1 | Error-group interrupt |
| cmd_word | output | 32 | Stored command word |

## Verification
Two sweeps cover every word of the window:

- **Reset sweep.** A read of every word after reset separates mapped words with reset values from unmapped ones.
- **Write-then-read sweep.** Each word gets a distinct hashed pattern, and then every word is read back. The comparison tells apart all five access classes, the alignment of base writes, and the base-to-pointer ordering.

Beyond the sweeps:

- **Halt writes.** Writes mixing halted and running queues separate the unconditional transmit restart from the conditional receive one.
- **Event clears.** A staged series of clears shows that each interrupt line drops only when its own group empties.
- **Priority and partial access.** A same-cycle set and clear shows that the set wins. Partial and misaligned accesses show that they have no effect.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;

  // word indices (byte address / 4)
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_EVENT = 1;
  localparam int unsigned IDX_ID    = 2;
  localparam int unsigned IDX_CMD   = 3;
  localparam int unsigned IDX_TXST  = 4;
  localparam int unsigned IDX_RXST  = 5;
  localparam int unsigned IDX_TXB   = 32;
  localparam int unsigned IDX_TXP   = 40;
  localparam int unsigned IDX_RXB   = 64;
  localparam int unsigned IDX_RXP   = 72;

  localparam int unsigned TXST_TOP = 31;
  localparam int unsigned RXST_TOP = 23;

  localparam logic [31:0] GRP_TX  = 32'h0000_0001;
  localparam logic [31:0] GRP_RX  = 32'h0000_0002;
  localparam logic [31:0] GRP_ERR = 32'h0000_FF00;

  typedef enum logic [3:0] {
    K_NONE, K_CTRL, K_EVENT, K_ID, K_CMD, K_TXST, K_RXST,
    K_TXB, K_TXP, K_RXB, K_RXP
  } reg_kind_e;

endpackage

// File: rtl/dmarf_decode.sv
module dmarf_decode
  import dmarf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NQ     = 8,
  localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [QW-1:0]     q
);
  int unsigned ii;

  always_comb begin
    ii   = 32'(addr[ADDR_W-1:2]);
    kind = K_NONE;
    q    = '0;
    if (ii == IDX_CTRL)       kind = K_CTRL;
    else if (ii == IDX_EVENT) kind = K_EVENT;
    else if (ii == IDX_ID)    kind = K_ID;
    else if (ii == IDX_CMD)   kind = K_CMD;
    else if (ii == IDX_TXST)  kind = K_TXST;
    else if (ii == IDX_RXST)  kind = K_RXST;
    else if (ii >= IDX_TXB && ii < IDX_TXB + NQ) begin kind = K_TXB; q = QW'(ii - IDX_TXB); end
    else if (ii >= IDX_TXP && ii < IDX_TXP + NQ) begin kind = K_TXP; q = QW'(ii - IDX_TXP); end
    else if (ii >= IDX_RXB && ii < IDX_RXB + NQ) begin kind = K_RXB; q = QW'(ii - IDX_RXB); end
    else if (ii >= IDX_RXP && ii < IDX_RXP + NQ) begin kind = K_RXP; q = QW'(ii - IDX_RXP); end
  end
endmodule

// File: rtl/dmarf_halt.sv
module dmarf_halt #(
  parameter int NQ            = 8,
  parameter int TOP_BIT       = 31,
  parameter bit ONLY_IF_CLEAR = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [31:0]   wdata,
  input  logic [NQ-1:0] halt_set,
  output logic [31:0]   word,
  output logic [NQ-1:0] restart
);
  logic [NQ-1:0] halt_q, wsel, fire;

  always_comb begin
    word = '0;
    for (int i = 0; i < NQ; i++) begin
      wsel[i]           = wdata[TOP_BIT-i];
      word[TOP_BIT-i]   = halt_q[i];
    end
  end

  generate
    if (ONLY_IF_CLEAR) begin : g_cond
      assign fire = wsel & ~halt_q;
    end else begin : g_any
      assign fire = wsel;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q  <= '0;
      restart <= '0;
    end else begin
      restart <= wr ? fire : '0;
      halt_q  <= (halt_q & ~(wr ? wsel : '0)) | halt_set;
    end
  end
endmodule

// File: rtl/dmarf_ring.sv
module dmarf_ring #(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 base_we,
  input  logic                 ptr_we,
  input  logic [QW-1:0]        q,
  input  logic [31:0]          wdata,
  output logic [NQ-1:0][31:0]  base,
  output logic [NQ-1:0][31:0]  ptr
);
  localparam logic [31:0] ALIGN_MASK = ~32'h7;

  for (genvar n = 0; n < NQ; n++) begin : g_q
    logic [31:0] b_q, p_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        b_q <= '0;
        p_q <= '0;
      end else if (base_we && q == QW'(n)) begin
        b_q <= wdata & ALIGN_MASK;
        p_q <= wdata & ALIGN_MASK;
      end else if (ptr_we && q == QW'(n)) begin
        p_q <= wdata;
      end
    end
    assign base[n] = b_q;
    assign ptr[n]  = p_q;
  end
endmodule

// File: rtl/dmarf_event.sv
module dmarf_event
  import dmarf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr_we,
  input  logic [31:0] wdata,
  input  logic [31:0] set,
  output logic [31:0] ev,
  output logic        tx_irq,
  output logic        rx_irq,
  output logic        err_irq
);
  logic [31:0] ev_nxt;

  always_comb ev_nxt = (ev & ~(clr_we ? wdata : 32'h0)) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev      <= '0;
      tx_irq  <= 1'b0;
      rx_irq  <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      ev      <= ev_nxt;
      tx_irq  <= |(ev_nxt & GRP_TX);
      rx_irq  <= |(ev_nxt & GRP_RX);
      err_irq <= |(ev_nxt & GRP_ERR);
    end
  end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dmarf_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          NQ       = 8,
  parameter logic [31:0] CTRL_RST = 32'h0000_0040,
  parameter logic [31:0] ID_VALUE = 32'h0D3A_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic              rvalid,
  output logic [31:0]       rdata,
  input  logic [31:0]       event_set,
  input  logic [NQ-1:0]     tx_halt_set,
  input  logic [NQ-1:0]     rx_halt_set,
  output logic [NQ-1:0]     tx_restart,
  output logic [NQ-1:0]     rx_restart,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              err_irq,
  output logic [31:0]       cmd_word
);
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;

  reg_kind_e   kind;
  logic [QW-1:0] q;
  logic        full, wr_ok, rd_ok;
  logic [31:0] ctrl_q, ev, tx_word, rx_word, rd_mux;
  logic [NQ-1:0][31:0] tx_base, tx_ptr, rx_base, rx_ptr;

  assign full  = (be == 4'hF) && (addr[1:0] == 2'b00);
  assign wr_ok = req && we && full;
  assign rd_ok = req && !we && full;

  dmarf_decode #(.ADDR_W(ADDR_W), .NQ(NQ)) u_dec (.addr(addr), .kind(kind), .q(q));

  dmarf_halt #(.NQ(NQ), .TOP_BIT(TXST_TOP), .ONLY_IF_CLEAR(1'b0)) u_txh (
    .clk(clk), .rst(rst), .wr(wr_ok && kind == K_TXST), .wdata(wdata),
    .halt_set(tx_halt_set), .word(tx_word), .restart(tx_restart));

  dmarf_halt #(.NQ(NQ), .TOP_BIT(RXST_TOP), .ONLY_IF_CLEAR(1'b1)) u_rxh (
    .clk(clk), .rst(rst), .wr(wr_ok && kind == K_RXST), .wdata(wdata),
    .halt_set(rx_halt_set), .word(rx_word), .restart(rx_restart));

  dmarf_ring #(.NQ(NQ)) u_txr (
    .clk(clk), .rst(rst), .base_we(wr_ok && kind == K_TXB),
    .ptr_we(wr_ok && kind == K_TXP), .q(q), .wdata(wdata),
    .base(tx_base), .ptr(tx_ptr));

  dmarf_ring #(.NQ(NQ)) u_rxr (
    .clk(clk), .rst(rst), .base_we(wr_ok && kind == K_RXB),
    .ptr_we(wr_ok && kind == K_RXP), .q(q), .wdata(wdata),
    .base(rx_base), .ptr(rx_ptr));

  dmarf_event u_ev (
    .clk(clk), .rst(rst), .clr_we(wr_ok && kind == K_EVENT), .wdata(wdata),
    .set(event_set), .ev(ev), .tx_irq(tx_irq), .rx_irq(rx_irq), .err_irq(err_irq));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RST;
      cmd_word <= '0;
    end else if (wr_ok) begin
      if (kind == K_CTRL) ctrl_q   <= wdata;
      if (kind == K_CMD)  cmd_word <= wdata;
    end
  end

  always_comb begin
    unique case (kind)
      K_CTRL:  rd_mux = ctrl_q;
      K_EVENT: rd_mux = ev;
      K_ID:    rd_mux = ID_VALUE;
      K_TXST:  rd_mux = tx_word;
      K_RXST:  rd_mux = rx_word;
      K_TXB:   rd_mux = tx_base[q];
      K_TXP:   rd_mux = tx_ptr[q];
      K_RXB:   rd_mux = rx_base[q];
      K_RXP:   rd_mux = rx_ptr[q];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= req && !we;
      rdata  <= rd_ok ? rd_mux : 32'h0;
    end
  end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk
  import dmarf_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] ID_VALUE = 32'h0D3A_0100
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [3:0]        be,
  input logic              rvalid,
  input logic [31:0]       rdata,
  input logic              tx_irq,
  input logic              rx_irq,
  input logic              err_irq,
  input logic [7:0]        tx_restart,
  input logic [7:0]        rx_restart
);
  logic full_rd, full_wr;
  assign full_rd = req && !we && be == 4'hF;
  assign full_wr = req && we && be == 4'hF;

  p_rvalid_r1: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(req && !we));
  p_cmd_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $past(full_rd && addr == ADDR_W'(IDX_CMD*4)) |-> rdata == 32'h0);
  p_id_value_r3: assert property (@(posedge clk) disable iff (rst)
    $past(full_rd && addr == ADDR_W'(IDX_ID*4)) |-> rdata == ID_VALUE);
  p_tx_restart_src_r4: assert property (@(posedge clk) disable iff (rst)
    (|tx_restart) |-> $past(full_wr && addr == ADDR_W'(IDX_TXST*4)));
  p_rx_restart_src_r5: assert property (@(posedge clk) disable iff (rst)
    (|rx_restart) |-> $past(full_wr && addr == ADDR_W'(IDX_RXST*4)));
  p_tx_irq_drop_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_irq) |-> $past(full_wr && addr == ADDR_W'(IDX_EVENT*4)));
  p_rx_irq_drop_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_irq) |-> $past(full_wr && addr == ADDR_W'(IDX_EVENT*4)));
  p_err_irq_drop_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(err_irq) |-> $past(full_wr && addr == ADDR_W'(IDX_EVENT*4)));
endmodule

bind dma_regfile dma_regfile_chk #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_chk (
  .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .be(be),
  .rvalid(rvalid), .rdata(rdata), .tx_irq(tx_irq), .rx_irq(rx_irq),
  .err_irq(err_irq), .tx_restart(tx_restart[7:0]), .rx_restart(rx_restart[7:0]));

// File: tb/test_dma_regfile.sv
`timescale 1ns/1ps
module test_dma_regfile;
  localparam int ADDR_W = 12;
  localparam int NQ = 8;
  localparam logic [31:0] CTRL_RST = 32'h0000_0040;
  localparam logic [31:0] ID_VALUE = 32'h0D3A_0100;
  localparam int NWORDS = 1 << (ADDR_W - 2);

  logic clk = 0, rst = 1, req = 0, we = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [3:0] be = 4'hF;
  logic [31:0] wdata = '0, event_set = '0;
  logic [NQ-1:0] tx_halt_set = '0, rx_halt_set = '0;
  logic rvalid, tx_irq, rx_irq, err_irq;
  logic [31:0] rdata, cmd_word;
  logic [NQ-1:0] tx_restart, rx_restart;

  int n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma_regfile #(.ADDR_W(ADDR_W), .NQ(NQ), .CTRL_RST(CTRL_RST), .ID_VALUE(ID_VALUE)) i_dma_regfile (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .be(be), .wdata(wdata),
    .rvalid(rvalid), .rdata(rdata), .event_set(event_set), .tx_halt_set(tx_halt_set),
    .rx_halt_set(rx_halt_set), .tx_restart(tx_restart), .rx_restart(rx_restart),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .err_irq(err_irq), .cmd_word(cmd_word));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk);
    req = 1; we = 1; addr = ADDR_W'(a); wdata = d; be = b;
    @(negedge clk);
    req = 0; we = 0; be = 4'hF;
  endtask

  task automatic rd(input int a, output logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk);
    req = 1; we = 0; addr = ADDR_W'(a); be = b;
    @(negedge clk);
    req = 0; be = 4'hF;
    if (!rvalid) begin n_checks++; n_fail++; $display("FAIL R1: rvalid 0 expected 1"); end
    d = rdata;
  endtask

  function automatic logic [31:0] pat(int i);
    return (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_5A5A;
  endfunction

  function automatic logic [31:0] exp_after(int i);
    if (i == 0) return pat(0);
    if (i == 2) return ID_VALUE;
    if (i >= 32 && i < 32 + NQ) return pat(i) & ~32'h7;
    if (i >= 40 && i < 40 + NQ) return pat(i);
    if (i >= 64 && i < 64 + NQ) return pat(i) & ~32'h7;
    if (i >= 72 && i < 72 + NQ) return pat(i);
    return 32'h0;
  endfunction

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state of outputs
    chk("R9 irqs", {29'h0, tx_irq, rx_irq, err_irq}, 32'h0);
    chk("R9 restarts", {16'h0, tx_restart, rx_restart}, 32'h0);
    // R3 R9 reset sweep of the whole window
    for (int i = 0; i < NWORDS; i++) begin
      rd(i * 4, d);
      chk("R3/R9 reset read", d, (i == 0) ? CTRL_RST : (i == 2) ? ID_VALUE : 32'h0);
    end
    // R2 R3 R6 write sweep then readback
    for (int i = 0; i < NWORDS; i++) wr(i * 4, pat(i));
    chk("R2 cmd_word", cmd_word, pat(3));
    for (int i = 0; i < NWORDS; i++) begin
      rd(i * 4, d);
      chk("R2/R3/R6 sweep read", d, exp_after(i));
    end
    // R6 base write mirrors aligned value into pointer
    wr(4 * (40 + 3), 32'h1234_5677);
    wr(4 * (32 + 3), 32'hCAFE_F00F);
    rd(4 * (40 + 3), d); chk("R6 tx ptr mirror", d, 32'hCAFE_F008);
    wr(4 * (64 + 6), 32'h0000_0007);
    rd(4 * (72 + 6), d); chk("R6 rx ptr mirror", d, 32'h0);
    // R1 partial and misaligned accesses
    wr(0, 32'hFFFF_FFFF, 4'h3);
    wr(2, 32'hFFFF_FFFF);
    rd(0, d); chk("R1 partial write ignored", d, pat(0));
    rd(0, d, 4'h1); chk("R1 partial read zero", d, 32'h0);
    // R4 transmit restart: unconditional, all together, one cycle
    @(negedge clk); tx_halt_set = 8'b0000_0010;
    @(negedge clk); tx_halt_set = '0;
    rd(16, d); chk("R4 halt bit q1", d, 32'h4000_0000);
    wr(16, 32'hC100_0000);
    chk("R4 tx_restart q0 q1 q7", {24'h0, tx_restart}, 32'h83);
    @(negedge clk);
    chk("R4 pulse one cycle", {24'h0, tx_restart}, 32'h0);
    rd(16, d); chk("R4 halt cleared", d, 32'h0);
    // R5 receive restart only where halt bit clear
    @(negedge clk); rx_halt_set = 8'b0000_0100;
    @(negedge clk); rx_halt_set = '0;
    rd(20, d); chk("R5 halt bit q2", d, 32'h0020_0000);
    wr(20, 32'h0024_0000);
    chk("R5 rx_restart q5 only", {24'h0, rx_restart}, 32'h20);
    rd(20, d); chk("R5 halt cleared", d, 32'h0);
    // R7 R8 event groups
    @(negedge clk); event_set = 32'h0010_1203;
    @(negedge clk); event_set = '0;
    chk("R8 all irqs up", {29'h0, tx_irq, rx_irq, err_irq}, 32'h7);
    rd(4, d); chk("R7 event bits", d, 32'h0010_1203);
    wr(4, 32'h0000_0200);
    chk("R8 err held by bit12", {29'h0, tx_irq, rx_irq, err_irq}, 32'h7);
    wr(4, 32'h0000_0001);
    chk("R8 tx drops alone", {29'h0, tx_irq, rx_irq, err_irq}, 32'h3);
    wr(4, 32'h0000_1000);
    chk("R8 err drops", {29'h0, tx_irq, rx_irq, err_irq}, 32'h2);
    wr(4, 32'h0000_0002);
    chk("R8 rx drops, bit20 raises none", {29'h0, tx_irq, rx_irq, err_irq}, 32'h0);
    rd(4, d); chk("R7 ungrouped bit kept", d, 32'h0010_0000);
    // R7 set wins over clear in the same cycle
    @(negedge clk);
    req = 1; we = 1; addr = 12'h004; wdata = 32'h0010_0100; event_set = 32'h0000_0100;
    @(negedge clk);
    req = 0; we = 0; event_set = '0;
    chk("R7 set wins irq", {31'h0, err_irq}, 32'h1);
    rd(4, d); chk("R7 set wins value", d, 32'h0000_0100);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule